// File: doc/BRIEF.md
# Repetition Timer with Capture and Compare

This block is a 16-bit up-counting timer for a larger chip. A prescaler divides the system clock before the counter sees it. The counter runs from zero up to a programmed top value and then wraps. A repetition counter sits between the wraps and the overflow event, so software can ask for an overflow only every N+1 periods. The divider setting is double-buffered: a new divider value waits in its register and only takes over at an overflow. This means a period that is already running is never stretched or cut short.

Two channels share the counter. A channel in capture mode synchronizes its input pin and stores the counter value on each rising edge. A channel in compare mode drives a level output and a match pulse from its compare value. Each channel has a preload switch. With preload off, a written compare value takes effect at once. With preload on, it waits in the data register and moves over at the next overflow. Software reaches every register through a single-cycle write port and a combinational read port.

Top module: `rep_timer`

## Requirements
- R1: The counter advances by one once every (divider + 1) clock cycles while running; with divider 0 it advances on every clock.
- R2: A divider write does not alter the counting rate until the next overflow event, after which the new divider is used.
- R3: While running, the counter steps 0, 1, …, period, then returns to 0 on the following advance.
- R4: With the enable bit (control bit 0) clear, or with period 0, the counter holds its value and no overflow event occurs.
- R5: A wrap raises `ovfEvt` for one clock (the clock in which the counter reads 0) only when the repetition down-counter is 0; it is then reloaded from the repetition register. Otherwise the wrap decrements it. It is 0 after reset.
- R6: After reset every readable register reads 0 and all outputs are low. Read/write addresses: 0 control, 1 divider, 2 period, 3 repetition, 4 counter, 5 channel 0 data, 6 channel 1 data.
- R7: For a channel in compare mode (control bit 1+c clear), `cmpOut[c]` is high exactly while the counter is below the active compare value. In capture mode it is low.
- R8: In compare mode, `ccEvt[c]` pulses for one clock right after the counter advances onto the active compare value.
- R9: With preload (control bit 3+c) clear, a channel data write becomes the active compare value at once. With it set, the write is only read back, and it becomes active at the next overflow event.
- R10: In capture mode (control bit 1+c set), a rising edge on `chIn[c]` stores the counter value into that channel's data register and pulses `ccEvt[c]`, three clocks after the pin changes. Falling edges and inputs of compare-mode channels are ignored.
- R11: A write to address 4 loads the counter directly and restarts the prescale phase; reading address 4 returns the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 16 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 16 | Read data for rdAddr, combinational |
| chIn | input | 2 | Asynchronous channel input pins |
| ovfEvt | output | 1 | Overflow event pulse |
| ccEvt | output | 2 | Per-channel capture or compare-match pulse |
| cmpOut | output | 2 | Per-channel compare output level |

## Verification
Register writes land on the clock edge that ends the write cycle. When enable is written, the first counter advance comes one edge later, so k edges after that write the counter reads k modulo (period + 1). `ovfEvt` and `ccEvt` are registered and appear in the cycle that follows the advance that causes them. `cmpOut` and `rdData` follow the registers with no extra delay. A capture shows up three edges after the pin toggles, because of the two synchronizer flops and the edge-detect flop. The bench turns each of these latencies into an absolute due cycle when it queues an expectation, and the monitor samples just before the next rising edge.

// File: rtl/rep_timer_pkg.sv
package rep_timer_pkg;
  localparam int CntW    = 16;
  localparam int NumCh   = 2;
  localparam int AddrW   = 3;
  localparam int SyncLen = 3;
  localparam int ModeLsb = 1;
  localparam int PreLsb  = ModeLsb + NumCh;
  localparam int CtrlW   = PreLsb + NumCh;

  localparam logic [AddrW-1:0] AdrCtrl = 3'd0;
  localparam logic [AddrW-1:0] AdrDiv  = 3'd1;
  localparam logic [AddrW-1:0] AdrPer  = 3'd2;
  localparam logic [AddrW-1:0] AdrRep  = 3'd3;
  localparam logic [AddrW-1:0] AdrCnt  = 3'd4;
  localparam int               AdrCh0  = 5;

  typedef struct packed {
    logic             enable;
    logic [NumCh-1:0] capMode;
    logic [NumCh-1:0] preload;
    logic [CntW-1:0]  div;
    logic [CntW-1:0]  period;
    logic [CntW-1:0]  rep;
  } tmrCfg_t;

  typedef struct packed {
    logic             cntWr;
    logic [NumCh-1:0] chWr;
    logic [CntW-1:0]  wrVal;
  } tmrCmd_t;
endpackage

// File: rtl/rep_timer_ctrl.sv
module rep_timer_ctrl
  import rep_timer_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [AddrW-1:0]            wrAddr,
  input  logic [CntW-1:0]             wrData,
  input  logic [AddrW-1:0]            rdAddr,
  input  logic [CntW-1:0]             cntVal,
  input  logic [NumCh-1:0][CntW-1:0]  chData,
  output tmrCfg_t                     cfg,
  output tmrCmd_t                     cmd,
  output logic [CntW-1:0]             rdData
);
  logic [CtrlW-1:0] ctrlReg;
  logic [CntW-1:0]  divReg;
  logic [CntW-1:0]  perReg;
  logic [CntW-1:0]  repReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      divReg  <= '0;
      perReg  <= '0;
      repReg  <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        AdrCtrl: ctrlReg <= wrData[CtrlW-1:0];
        AdrDiv:  divReg  <= wrData;
        AdrPer:  perReg  <= wrData;
        AdrRep:  repReg  <= wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg.enable  = ctrlReg[0];
    cfg.capMode = ctrlReg[ModeLsb +: NumCh];
    cfg.preload = ctrlReg[PreLsb +: NumCh];
    cfg.div     = divReg;
    cfg.period  = perReg;
    cfg.rep     = repReg;
  end

  always_comb begin
    cmd.cntWr = wrEn && (wrAddr == AdrCnt);
    cmd.wrVal = wrData;
    for (int c = 0; c < NumCh; c++) begin
      cmd.chWr[c] = wrEn && (int'(wrAddr) == AdrCh0 + c);
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      AdrCtrl: rdData = CntW'(ctrlReg);
      AdrDiv:  rdData = divReg;
      AdrPer:  rdData = perReg;
      AdrRep:  rdData = repReg;
      AdrCnt:  rdData = cntVal;
      default: begin
        for (int c = 0; c < NumCh; c++) begin
          if (int'(rdAddr) == AdrCh0 + c) rdData = chData[c];
        end
      end
    endcase
  end
endmodule

// File: rtl/rep_timer_chan.sv
module rep_timer_chan
  import rep_timer_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            capMode,
  input  logic            preload,
  input  logic            wrStb,
  input  logic [CntW-1:0] wrVal,
  input  logic [CntW-1:0] cnt,
  input  logic [CntW-1:0] cntNext,
  input  logic            adv,
  input  logic            ovf,
  input  logic            pinIn,
  output logic [CntW-1:0] dataReg,
  output logic            evt,
  output logic            cmpOut
);
  logic [SyncLen-1:0] syncQ;
  logic [CntW-1:0]    cmpAct;
  logic               rise;
  logic               capHit;
  logic               matchHit;

  assign rise     = syncQ[SyncLen-2] & ~syncQ[SyncLen-1];
  assign capHit   = capMode && rise;
  assign matchHit = !capMode && adv && (cntNext == cmpAct);
  assign cmpOut   = !capMode && (cnt < cmpAct);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      dataReg <= '0;
      cmpAct  <= '0;
      evt     <= 1'b0;
    end else begin
      syncQ <= {syncQ[SyncLen-2:0], pinIn};
      if (capHit)     dataReg <= cnt;
      else if (wrStb) dataReg <= wrVal;
      if (wrStb && !preload)     cmpAct <= wrVal;
      else if (ovf && preload)   cmpAct <= dataReg;
      evt <= capHit || matchHit;
    end
  end
endmodule

// File: rtl/rep_timer_dp.sv
module rep_timer_dp
  import rep_timer_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  tmrCfg_t                     cfg,
  input  tmrCmd_t                     cmd,
  input  logic [NumCh-1:0]            chIn,
  output logic [CntW-1:0]             cntVal,
  output logic [NumCh-1:0][CntW-1:0]  chData,
  output logic                        ovfEvt,
  output logic [NumCh-1:0]            ccEvt,
  output logic [NumCh-1:0]            cmpOut
);
  logic [CntW-1:0] psCnt;
  logic [CntW-1:0] divAct;
  logic [CntW-1:0] repCnt;
  logic [CntW-1:0] cnt;
  logic [CntW-1:0] cntNext;
  logic            run;
  logic            tick;
  logic            adv;
  logic            wrap;
  logic            ovf;

  assign run  = cfg.enable && (cfg.period != '0);
  assign tick = run && (psCnt >= divAct);
  assign adv  = tick && !cmd.cntWr;
  assign wrap = adv && (cnt >= cfg.period);
  assign ovf  = wrap && (repCnt == '0);

  always_comb begin
    cntNext = cnt;
    if (cmd.cntWr)  cntNext = cmd.wrVal;
    else if (wrap)  cntNext = '0;
    else if (tick)  cntNext = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psCnt  <= '0;
      divAct <= '0;
      repCnt <= '0;
      cnt    <= '0;
      ovfEvt <= 1'b0;
    end else begin
      cnt <= cntNext;
      if (cmd.cntWr) psCnt <= '0;
      else if (run)  psCnt <= tick ? '0 : psCnt + 1'b1;
      if (wrap)      repCnt <= (repCnt == '0) ? cfg.rep : repCnt - 1'b1;
      if (ovf)       divAct <= cfg.div;
      ovfEvt <= ovf;
    end
  end

  assign cntVal = cnt;

  for (genvar c = 0; c < NumCh; c++) begin : gCh
    rep_timer_chan uChan (
      .clk     (clk),
      .rstN    (rstN),
      .capMode (cfg.capMode[c]),
      .preload (cfg.preload[c]),
      .wrStb   (cmd.chWr[c]),
      .wrVal   (cmd.wrVal),
      .cnt     (cnt),
      .cntNext (cntNext),
      .adv     (adv),
      .ovf     (ovf),
      .pinIn   (chIn[c]),
      .dataReg (chData[c]),
      .evt     (ccEvt[c]),
      .cmpOut  (cmpOut[c])
    );
  end
endmodule

// File: rtl/rep_timer.sv
module rep_timer
  import rep_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AddrW-1:0]  wrAddr,
  input  logic [CntW-1:0]   wrData,
  input  logic [AddrW-1:0]  rdAddr,
  output logic [CntW-1:0]   rdData,
  input  logic [NumCh-1:0]  chIn,
  output logic              ovfEvt,
  output logic [NumCh-1:0]  ccEvt,
  output logic [NumCh-1:0]  cmpOut
);
  tmrCfg_t                     cfg;
  tmrCmd_t                     cmd;
  logic [CntW-1:0]             cntVal;
  logic [NumCh-1:0][CntW-1:0]  chData;

  rep_timer_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .cntVal (cntVal),
    .chData (chData),
    .cfg    (cfg),
    .cmd    (cmd),
    .rdData (rdData)
  );

  rep_timer_dp uDp (
    .clk    (clk),
    .rstN   (rstN),
    .cfg    (cfg),
    .cmd    (cmd),
    .chIn   (chIn),
    .cntVal (cntVal),
    .chData (chData),
    .ovfEvt (ovfEvt),
    .ccEvt  (ccEvt),
    .cmpOut (cmpOut)
  );
endmodule

// File: rtl/rep_timer_chk.sv
module rep_timer_chk
  import rep_timer_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            ovfEvt,
  input logic            runEn,
  input logic            cntWr,
  input logic [CntW-1:0] cntVal,
  input logic [CntW-1:0] perVal
);
  // R5
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt |=> !ovfEvt);

  // R5
  ovf_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt |-> (cntVal == '0));

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWr && (!runEn || perVal == '0)) |=> $stable(cntVal));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWr && (cntVal < perVal)) |=>
      ((cntVal == $past(cntVal)) || (cntVal == $past(cntVal) + 1'b1)));
endmodule

bind rep_timer rep_timer_chk uChk (
  .clk    (clk),
  .rstN   (rstN),
  .ovfEvt (ovfEvt),
  .runEn  (cfg.enable),
  .cntWr  (cmd.cntWr),
  .cntVal (cntVal),
  .perVal (cfg.period)
);

// File: tb/tb_rep_timer.sv
`timescale 1ns/1ps
module tb_rep_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic [1:0]  chIn = '0;
  logic        ovfEvt;
  logic [1:0]  ccEvt;
  logic [1:0]  cmpOut;

  localparam int SigOvf = 0, SigEv0 = 1, SigEv1 = 2, SigCo0 = 3, SigCo1 = 4, SigRd = 5;

  typedef struct {
    int          due;
    int          sig;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    nChecks = 0;
  int    nFail = 0;
  bit    done = 0;

  rep_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .chIn(chIn), .ovfEvt(ovfEvt),
    .ccEvt(ccEvt), .cmpOut(cmpOut)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] sigVal(int s);
    case (s)
      SigOvf:  return 16'(ovfEvt);
      SigEv0:  return 16'(ccEvt[0]);
      SigEv1:  return 16'(ccEvt[1]);
      SigCo0:  return 16'(cmpOut[0]);
      SigCo1:  return 16'(cmpOut[1]);
      default: return rdData;
    endcase
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: samples just before the next rising edge
  always @(negedge clk) begin
    #3;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        check(q[i].req, $sformatf("sig%0d@%0d", q[i].sig, cyc), sigVal(q[i].sig), q[i].exp);
        q.delete(i);
      end
    end
  end

  task automatic expectAt(int dly, int sig, logic [15:0] v, string req);
    item_t it;
    it.due = cyc + dly; it.sig = sig; it.exp = v; it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; chIn = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int b, w, c;
    // R6 reset state
    doReset();
    for (int a = 0; a < 7; a++) begin
      @(negedge clk); rdAddr = 3'(a); #2;
      check("R6", $sformatf("reg%0d", a), rdData, 16'h0);
    end
    check("R6", "ovfEvt", 16'(ovfEvt), 16'h0);
    check("R6", "ccEvt", 16'(ccEvt), 16'h0);
    check("R6", "cmpOut", 16'(cmpOut), 16'h0);

    // R3 / R5 / R1: period 3, divider 0, repetition 0
    doReset(); rdAddr = 3'd4;
    wr(3'd2, 16'd3); wr(3'd0, 16'd1);
    for (int k = 1; k <= 9; k++) begin
      expectAt(k, SigRd, 16'(k % 4), "R3");
      expectAt(k, SigOvf, 16'(k % 4 == 0), "R5");
    end
    drain();

    // R5 repetition = 2
    doReset(); rdAddr = 3'd4;
    wr(3'd3, 16'd2); wr(3'd2, 16'd3); wr(3'd0, 16'd1);
    expectAt(4, SigOvf, 16'd1, "R5");
    expectAt(8, SigOvf, 16'd0, "R5");
    expectAt(12, SigOvf, 16'd0, "R5");
    expectAt(16, SigOvf, 16'd1, "R5");
    expectAt(20, SigOvf, 16'd0, "R5");
    drain();

    // R1 / R2 buffered divider
    doReset(); rdAddr = 3'd4;
    wr(3'd2, 16'd3); wr(3'd1, 16'd2); wr(3'd0, 16'd1);
    expectAt(3, SigRd, 16'd3, "R2");
    expectAt(4, SigRd, 16'd0, "R2");
    expectAt(4, SigOvf, 16'd1, "R2");
    expectAt(6, SigRd, 16'd0, "R1");
    expectAt(7, SigRd, 16'd1, "R1");
    expectAt(10, SigRd, 16'd2, "R1");
    expectAt(13, SigRd, 16'd3, "R1");
    expectAt(13, SigOvf, 16'd0, "R1");
    expectAt(16, SigRd, 16'd0, "R1");
    expectAt(16, SigOvf, 16'd1, "R1");
    drain();

    // R4 zero period and enable clear; R11 counter write
    doReset(); rdAddr = 3'd4;
    wr(3'd0, 16'd1);
    for (int k = 1; k <= 5; k++) expectAt(k, SigRd, 16'd0, "R4");
    expectAt(3, SigOvf, 16'd0, "R4");
    drain();
    wr(3'd2, 16'd5); wr(3'd0, 16'd0);
    for (int k = 0; k <= 5; k++) expectAt(k, SigRd, 16'd2, "R4");
    drain();
    wr(3'd4, 16'h1234);
    expectAt(0, SigRd, 16'h1234, "R11");
    expectAt(3, SigRd, 16'h1234, "R11");
    drain();

    // R7 / R8 compare, preload off; R9 immediate update
    doReset();
    wr(3'd2, 16'd7); wr(3'd5, 16'd3); wr(3'd0, 16'd1);
    b = cyc;
    for (int k = 0; k <= 9; k++) expectAt(k, SigCo0, 16'((k % 8) < 3), "R7");
    expectAt(2, SigEv0, 16'd0, "R8");
    expectAt(3, SigEv0, 16'd1, "R8");
    expectAt(4, SigEv0, 16'd0, "R8");
    expectAt(11, SigEv0, 16'd1, "R8");
    drain();
    wr(3'd5, 16'd6);
    w = cyc;
    for (int d = 0; d < 8; d++) expectAt(d, SigCo0, 16'(((w + d - b) % 8) < 6), "R9");
    drain();

    // R9 preload on channel 1
    doReset(); rdAddr = 3'd6;
    wr(3'd0, 16'h0010); wr(3'd2, 16'd3); wr(3'd6, 16'd2);
    expectAt(0, SigRd, 16'd2, "R9");
    expectAt(0, SigCo1, 16'd0, "R9");
    drain();
    wr(3'd0, 16'h0011);
    expectAt(1, SigCo1, 16'd0, "R9");
    expectAt(3, SigCo1, 16'd0, "R9");
    expectAt(4, SigCo1, 16'd1, "R9");
    expectAt(5, SigCo1, 16'd1, "R9");
    expectAt(6, SigCo1, 16'd0, "R9");
    expectAt(5, SigEv1, 16'd0, "R8");
    expectAt(6, SigEv1, 16'd1, "R8");
    drain();

    // R10 capture on channel 0, channel 1 stays in compare mode
    doReset(); rdAddr = 3'd5;
    wr(3'd0, 16'h0002); wr(3'd4, 16'd9);
    @(negedge clk); chIn = 2'b11;
    expectAt(2, SigEv0, 16'd0, "R10");
    expectAt(2, SigRd, 16'd0, "R10");
    expectAt(3, SigEv0, 16'd1, "R10");
    expectAt(3, SigRd, 16'd9, "R11");
    expectAt(3, SigEv1, 16'd0, "R10");
    expectAt(3, SigCo0, 16'd0, "R7");
    expectAt(4, SigEv0, 16'd0, "R10");
    drain();
    @(negedge clk); chIn = 2'b00;
    wr(3'd4, 16'd20);
    for (int d = 0; d < 4; d++) begin
      expectAt(d, SigRd, 16'd9, "R10");
      expectAt(d, SigEv0, 16'd0, "R10");
    end
    drain();
    @(negedge clk); chIn = 2'b01;
    c = cyc;
    expectAt(3, SigRd, 16'd20, "R10");
    expectAt(3, SigEv0, 16'd1, "R10");
    drain();
    if (c < 0) $display("unreachable");

    finishRun();
  end
endmodule